// File: doc/BRIEF.md
# Time-Stamp Record Queue with Word-Serial Readout

This block holds the time-stamp records of one direction (transmit or receive) of one network port. Whenever the upstream frame detector sees a precision-time event frame, it pulses a capture strobe together with a complete record: message tag, 48-bit seconds, 32-bit nanoseconds, 64-bit source clock identity, source port number and sequence ID. The block queues these records in a first-in first-out store.

Software empties the queue through one data register. Each read returns the next 16-bit word of the oldest record in the low half of a 32-bit value. A status register shows the enable bit, the word position inside the current record, and a count of records that were lost because the queue was full. Writing the status register sets the enable bit and clears the lost-record count. Clearing the enable bit also flushes the queue.

The block also drives its own not-empty flag into a shared six-bit buffer-status word, at a position set by its port index and direction. It raises an interrupt when that flag is set and its mask bit is set.

Top module: `ts_record_fifo`

## Requirements
- R1: After reset the queue is empty, the enable bit is 0, the read position is 0, the lost count is 0, and the data register, the not-empty word and the interrupt all read 0.
- R2: A record is read as twelve 16-bit words: tag (1), seconds (3), nanoseconds (2), clock identity (4), port number (1), sequence ID (1). Multi-word fields come out most significant word first. Bits 31:16 of the data register read as 0.
- R3: Each data-register read of a non-empty queue advances the read position by one, from 0 to 11. The read after word 11 pops the record, and the position returns to 0, where the next record begins.
- R4: A data-register read while the queue is empty returns 0 and leaves the read position unchanged.
- R5: The queue holds DEPTH records (90 by default). A capture that arrives while the queue is full is discarded and raises the lost count by one. The count saturates at 15.
- R6: Any write to the status register clears the lost count and loads the enable bit from bit 15 of the written value.
- R7: While the enable bit is 0, captures are ignored and the queue does not fill.
- R8: Writing 0 to bit 15 of the status register empties the queue and sets the read position to 0 in the next cycle.
- R9: The not-empty flag sits in the shared word at bit PORT_IDX for transmit and at bit NUM_PORTS+PORT_IDX for receive. All other bits of the shared word are 0.
- R10: The interrupt is the not-empty word ANDed with the mask input and then ORed. It stays asserted until the queue is drained or flushed.
- R11: The status register reads the enable bit at bit 15, the read position at bits 12:8 and the lost count at bits 7:4. All other bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cap_valid | input | 1 | Capture strobe, one record per pulse |
| cap_tag | input | 16 | Message tag |
| cap_sec | input | 48 | Seconds value |
| cap_nsec | input | 32 | Nanoseconds value |
| cap_clkid | input | 64 | Source clock identity |
| cap_portnum | input | 16 | Source port number |
| cap_seqid | input | 16 | Sequence ID |
| rd_strobe | input | 1 | Data-register read pulse; advances the readout |
| rd_data | output | 32 | Current word of the oldest record, low 16 bits |
| stat_wr | input | 1 | Status-register write pulse |
| stat_wdata | input | 32 | Status write value; bit 15 is the enable bit |
| stat_rdata | output | 32 | Status register read value |
| irq_mask | input | 6 | Interrupt mask, same layout as the not-empty word |
| ne_bits | output | 6 | This block's share of the buffer-status word |
| irq_bits | output | 6 | This block's share of the interrupt-status word |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with DEPTH set to 4, PORT_IDX set to 1 and the receive direction selected. A depth of four lets a few captures fill the queue, and sixteen extra captures drive the lost count past its saturation point within a short run. With port 1 on the receive side, the flag lands at bit 4 of the shared word, away from bit 0, so a wrong position calculation shows up. Readouts are broken off partway through a record so that the flush and the position reset can be seen at a non-zero word.

// File: rtl/tsfifo_pkg.sv
package tsfifo_pkg;
  localparam int WORD_W    = 16;
  localparam int REC_WORDS = 12;
  localparam int REC_W     = WORD_W * REC_WORDS;
  localparam int POS_W     = 5;
  localparam int DISC_W    = 4;
  localparam int EN_BIT    = 15;

  typedef logic [REC_W-1:0] rec_t;

  // pack the fields, tag in the top word, sequence ID in the bottom word
  function automatic rec_t pack_rec(input logic [15:0] tag, input logic [47:0] sec,
                                    input logic [31:0] nsec, input logic [63:0] clkid,
                                    input logic [15:0] portnum, input logic [15:0] seqid);
    return {tag, sec, nsec, clkid, portnum, seqid};
  endfunction

  // word at a readout position, most significant word first
  function automatic logic [WORD_W-1:0] rec_word(input rec_t rec, input logic [POS_W-1:0] pos);
    logic [WORD_W-1:0] w;
    w = '0;
    for (int i = 0; i < REC_WORDS; i++)
      if (int'(pos) == i) w = rec[REC_W-1-WORD_W*i -: WORD_W];
    return w;
  endfunction

  function automatic logic [31:0] status_word(input logic en, input logic [POS_W-1:0] pos,
                                              input logic [DISC_W-1:0] disc);
    return {16'h0, en, 2'b00, pos, disc, 4'h0};
  endfunction

  function automatic int ne_index(input int num_ports, input int port_idx, input bit is_rx);
    return is_rx ? num_ports + port_idx : port_idx;
  endfunction
endpackage

// File: rtl/tsfifo_store.sv
module tsfifo_store
  import tsfifo_pkg::*;
#(
  parameter int DEPTH = 90
) (
  input  logic clk,
  input  logic rst_n,
  input  logic push_req,
  input  rec_t rec_in,
  input  logic pop,
  input  logic flush,
  output logic empty,
  output logic drop,
  output rec_t head
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  rec_t          mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] cnt;
  logic          full, wr_evt, pop_evt;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (cnt == CW'(DEPTH));
  assign empty   = (cnt == '0);
  assign wr_evt  = push_req && !flush && !full;
  assign drop    = push_req && !flush && full;
  assign pop_evt = pop && !empty && !flush;
  assign head    = mem[rptr];

  always_ff @(posedge clk) begin
    if (wr_evt) mem[wptr] <= rec_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (wr_evt)  wptr <= bump(wptr);
      if (pop_evt) rptr <= bump(rptr);
      case ({wr_evt, pop_evt})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  a_r5_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  a_r8_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
  a_r10_ne_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty && !pop && !flush) |=> !empty);
endmodule

// File: rtl/tsfifo_reader.sv
module tsfifo_reader
  import tsfifo_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rd_strobe,
  input  logic             empty,
  input  logic             flush,
  output logic [POS_W-1:0] pos,
  output logic             pop
);
  localparam logic [POS_W-1:0] LAST = POS_W'(REC_WORDS - 1);

  logic advance;
  assign advance = rd_strobe && !empty && !flush;
  assign pop     = advance && (pos == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || flush)  pos <= '0;
    else if (pop)         pos <= '0;
    else if (advance)     pos <= pos + 1'b1;
  end

  a_r3_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
    pos <= LAST);
  a_r3_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> (pos == '0));
  a_r4_empty_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_strobe && empty && !flush) |=> $stable(pos));
endmodule

// File: rtl/tsfifo_ctrl.sv
module tsfifo_ctrl
  import tsfifo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stat_wr,
  input  logic [31:0]       stat_wdata,
  input  logic              drop,
  output logic              en,
  output logic              flush,
  output logic [DISC_W-1:0] disc
);
  localparam logic [DISC_W-1:0] DMAX = '1;

  assign flush = stat_wr && !stat_wdata[EN_BIT];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en   <= 1'b0;
      disc <= '0;
    end else if (stat_wr) begin
      en   <= stat_wdata[EN_BIT];
      disc <= '0;
    end else if (drop && disc != DMAX) begin
      disc <= disc + 1'b1;
    end
  end

  a_r5_disc_sat: assert property (@(posedge clk) disable iff (!rst_n)
    (disc == DMAX && !stat_wr) |=> (disc == DMAX));
  a_r6_write_clears: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wr |=> (disc == '0));
endmodule

// File: rtl/ts_record_fifo.sv
module ts_record_fifo
  import tsfifo_pkg::*;
#(
  parameter int DEPTH     = 90,
  parameter int NUM_PORTS = 3,
  parameter int PORT_IDX  = 0,
  parameter bit IS_RX     = 1'b0
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cap_valid,
  input  logic [15:0]            cap_tag,
  input  logic [47:0]            cap_sec,
  input  logic [31:0]            cap_nsec,
  input  logic [63:0]            cap_clkid,
  input  logic [15:0]            cap_portnum,
  input  logic [15:0]            cap_seqid,
  input  logic                   rd_strobe,
  output logic [31:0]            rd_data,
  input  logic                   stat_wr,
  input  logic [31:0]            stat_wdata,
  output logic [31:0]            stat_rdata,
  input  logic [2*NUM_PORTS-1:0] irq_mask,
  output logic [2*NUM_PORTS-1:0] ne_bits,
  output logic [2*NUM_PORTS-1:0] irq_bits,
  output logic                   irq
);
  localparam int SW     = 2 * NUM_PORTS;
  localparam int NE_BIT = ne_index(NUM_PORTS, PORT_IDX, IS_RX);

  logic              en, flush, drop, empty, pop;
  logic [POS_W-1:0]  pos;
  logic [DISC_W-1:0] disc;
  rec_t              head;

  tsfifo_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .stat_wr(stat_wr), .stat_wdata(stat_wdata),
    .drop(drop), .en(en), .flush(flush), .disc(disc)
  );

  tsfifo_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst_n(rst_n), .push_req(cap_valid && en),
    .rec_in(pack_rec(cap_tag, cap_sec, cap_nsec, cap_clkid, cap_portnum, cap_seqid)),
    .pop(pop), .flush(flush), .empty(empty), .drop(drop), .head(head)
  );

  tsfifo_reader u_reader (
    .clk(clk), .rst_n(rst_n), .rd_strobe(rd_strobe), .empty(empty),
    .flush(flush), .pos(pos), .pop(pop)
  );

  assign rd_data    = empty ? 32'h0 : {16'h0, rec_word(head, pos)};
  assign stat_rdata = status_word(en, pos, disc);

  for (genvar g = 0; g < SW; g++) begin : g_ne
    if (g == NE_BIT) begin : g_own
      assign ne_bits[g] = !empty;
    end else begin : g_other
      assign ne_bits[g] = 1'b0;
    end
  end

  assign irq_bits = ne_bits & irq_mask;
  assign irq      = |irq_bits;

  a_r7_disabled_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && empty) |=> empty);
  a_r9_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(ne_bits));
endmodule

// File: tb/ts_record_fifo_bench.sv
module ts_record_fifo_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;
  localparam int NP = 3;
  localparam int PIDX = 1;
  localparam int NEB = NP + PIDX;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cap_valid = 1'b0;
  logic [191:0] cur = '0;
  logic rd_strobe = 1'b0;
  logic stat_wr = 1'b0;
  logic [31:0] stat_wdata = '0;
  logic [5:0] irq_mask = '0;
  logic [31:0] rd_data, stat_rdata;
  logic [5:0] ne_bits, irq_bits;
  logic irq;

  int total = 0, bad = 0, cycles = 0;
  logic [191:0] sb[$];
  int m_pos = 0, m_disc = 0;
  bit m_en = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ts_record_fifo #(.DEPTH(DEPTH), .NUM_PORTS(NP), .PORT_IDX(PIDX), .IS_RX(1'b1)) u_ts_record_fifo (
    .clk(clk), .rst_n(rst_n), .cap_valid(cap_valid),
    .cap_tag(cur[191:176]), .cap_sec(cur[175:128]), .cap_nsec(cur[127:96]),
    .cap_clkid(cur[95:32]), .cap_portnum(cur[31:16]), .cap_seqid(cur[15:0]),
    .rd_strobe(rd_strobe), .rd_data(rd_data), .stat_wr(stat_wr),
    .stat_wdata(stat_wdata), .stat_rdata(stat_rdata), .irq_mask(irq_mask),
    .ne_bits(ne_bits), .irq_bits(irq_bits), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // word i of a record built word-by-word, word 0 placed in the top bits
  function automatic logic [191:0] mk(input int seed);
    logic [191:0] r;
    for (int i = 0; i < 12; i++)
      r[191-16*i -: 16] = {8'(seed * 7 + 3), 4'(i), 4'(seed)};
    return r;
  endfunction

  function automatic logic [31:0] exp_stat();
    return {16'h0, m_en, 2'b00, 5'(m_pos), 4'(m_disc), 4'h0};
  endfunction

  task automatic capture(input int seed);
    @(negedge clk);
    cur = mk(seed);
    cap_valid = 1'b1;
    @(negedge clk);
    cap_valid = 1'b0;
    if (m_en) begin
      if (sb.size() < DEPTH) sb.push_back(cur);
      else if (m_disc < 15) m_disc++;
    end
  endtask

  task automatic write_stat(input logic [31:0] v);
    @(negedge clk);
    stat_wr = 1'b1;
    stat_wdata = v;
    @(negedge clk);
    stat_wr = 1'b0;
    m_en = v[15];
    m_disc = 0;
    if (!v[15]) begin
      sb.delete();
      m_pos = 0;
    end
  endtask

  // monitor side of the scoreboard: compare the current word, then read it
  task automatic read_word(input string req);
    logic [31:0] exp;
    @(negedge clk);
    exp = (sb.size() == 0) ? 32'h0 : {16'h0, sb[0][191-16*m_pos -: 16]};
    chk(req, rd_data, exp);
    chk({req, " pos"}, 32'(stat_rdata[12:8]), 32'(m_pos));
    rd_strobe = 1'b1;
    @(negedge clk);
    rd_strobe = 1'b0;
    if (sb.size() != 0) begin
      if (m_pos == 11) begin
        m_pos = 0;
        void'(sb.pop_front());
      end else m_pos++;
    end
  endtask

  task automatic drain_one(input string req);
    for (int i = 0; i < 12; i++) read_word(req);
  endtask

  initial begin
    while (cycles < 20000) begin
      @(posedge clk);
      cycles++;
    end
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 status", stat_rdata, 32'h0);
    chk("R1 data", rd_data, 32'h0);
    chk("R1 ne", 32'(ne_bits), 32'h0);
    chk("R1 irq", 32'(irq), 32'h0);

    // R7 capture while disabled is ignored
    capture(1);
    chk("R7 ne after disabled capture", 32'(ne_bits), 32'h0);

    // R6/R11 enable via status write
    write_stat(32'h0000_8000);
    chk("R11 status enabled", stat_rdata, exp_stat());

    capture(2);
    capture(3);
    // R9 flag position
    chk("R9 ne position", 32'(ne_bits), 32'(1) << NEB);
    irq_mask = 6'b000001;
    @(negedge clk);
    chk("R10 masked irq", 32'(irq), 32'h0);
    irq_mask = 6'b111111;
    @(negedge clk);
    chk("R10 irq asserted", 32'(irq), 32'h1);
    chk("R10 irq bits", 32'(irq_bits), 32'(1) << NEB);

    // R2/R3 word order and record boundary
    drain_one("R2 rec A");
    chk("R3 boundary pos", 32'(stat_rdata[12:8]), 32'h0);
    chk("R10 irq held", 32'(irq), 32'h1);
    drain_one("R3 rec B");
    chk("R10 irq after drain", 32'(irq), 32'h0);
    chk("R10 ne after drain", 32'(ne_bits), 32'h0);

    // R4 empty read
    read_word("R4 empty read");
    read_word("R4 empty read again");

    // R5 overflow and saturation
    for (int k = 0; k < 6; k++) capture(10 + k);
    chk("R5 lost count 2", stat_rdata, exp_stat());
    for (int k = 0; k < 14; k++) capture(20 + k);
    chk("R5 lost count saturated", 32'(stat_rdata[7:4]), 32'd15);

    // R6 write clears count, keeps queue
    write_stat(32'h0000_8000);
    chk("R6 count cleared", stat_rdata, exp_stat());
    drain_one("R5 oldest kept");
    for (int k = 0; k < 5; k++) read_word("R3 partial");
    chk("R3 mid pos", stat_rdata, exp_stat());

    // R8 flush on disable
    write_stat(32'h0);
    chk("R8 status after flush", stat_rdata, 32'h0);
    chk("R8 ne after flush", 32'(ne_bits), 32'h0);
    capture(40);
    chk("R7 ignored after disable", 32'(ne_bits), 32'h0);

    write_stat(32'h0000_8000);
    capture(41);
    drain_one("R8 fresh record after flush");
    chk("R3 end status", stat_rdata, exp_stat());

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule